// File: doc/BRIEF.md
# Stored-Vector Output Checker with Per-Bit Failure Histogram

This block exercises a device under test at full clock rate. It plays a table of pseudo-random stimulus words to the device. Both the stimulus table and the matching table of expected results are fixed when the design is built, from parameters, and live inside the block. The block compares every bit of every result the device returns against the expected word. It keeps three pieces of state:

- a sticky failure flag;
- a saturating count of failed result words;
- one saturating failure counter for each result bit position.

A supervising host runs the block while it changes the operating point of the device, for example its clock frequency. It watches the flag to decide whether the operating point is safe. Afterwards it reads the per-bit counters one at a time through an index-addressed read port. The counters show which output bits fail first.

The stimulus word is split into two halves. The reference function is the full-width product of those halves, so a 32 by 32 multiplier with a 64-bit product is the default target. The device's pipeline depth is a parameter. The expected word is delayed by that depth so that each result is checked against the vector that produced it.

Top module: `stored_vector_checker`

## Requirements
- R1: Stimulus entry i (0 <= i < DEPTH) has two halves. The upper half, bits [2*HALF_W-1:HALF_W], is the low HALF_W bits of mix(SEED, 2i). The lower half is the low HALF_W bits of mix(SEED, 2i+1). mix(s,k) is computed on 32 bits, all products truncated to 32 bits, in three steps:
  - x = s ^ (k * 0x9E3779B9);
  - x = x * 0x7FEB352D;
  - result = x ^ (x >> 15).
- R2: Expected entry i is the unsigned product of the two halves of stimulus entry i, 2*HALF_W bits wide.
- R3: Vector order and pausing.
  - At each rising edge where run_en is high, the block drives the next table entry on stim_o and sets stim_vld_o high.
  - After reset the first entry is 0. Entries run 0 to DEPTH-1 and then wrap to 0.
  - At an edge where run_en is low, stim_vld_o goes low, stim_o holds its value and the table position is kept.
- R4: The value on res_i in cycle c+LATENCY is compared with the expected entry of the vector shown on stim_o in cycle c, provided stim_vld_o was high in cycle c. In all other cycles res_i is ignored.
- R5: Any compared word with at least one differing bit sets err_flag_o in the following cycle. The flag stays high until reset.
- R6: err_cnt_o rises by exactly one for each compared word that differs, whatever the number of differing bits. It saturates at all ones.
- R7: Histogram counter b (HCNT_W bits, 16 by default) rises by one for each compared word whose bit b differs from the expected bit. It saturates at 2^HCNT_W-1.
- R8: hist_cnt_o shows counter hist_idx_i as sampled at the previous rising edge (one cycle read latency). An index at or above the result width reads 0.
- R9: A synchronous active-high rst clears the flag, the failure count, every histogram counter, the read output, stim_vld_o and the table position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Advance through the vector table while high |
| stim_o | output | 2*HALF_W | Stimulus word to the device under test |
| stim_vld_o | output | 1 | stim_o carries a fresh vector this cycle |
| res_i | input | 2*HALF_W | Result word from the device under test |
| err_flag_o | output | 1 | Sticky failure flag |
| err_cnt_o | output | ERR_W | Saturating count of failed words |
| hist_idx_i | input | clog2(2*HALF_W) | Bit index of the histogram counter to read |
| hist_cnt_o | output | HCNT_W | Histogram counter read data, one cycle after the index |

## Verification
The bench models the device under test as a two-stage product pipeline with a fault mask on its output. A clean run of more than two table passes gives zero failures only if both the table contents and the latency alignment are right. An off-by-one delay line would flag nearly every word.

Multi-bit faults must add one to the word count but one to each affected bit counter. A design that counted bits would over-count.

Faults applied while paused must leave all counts alone, and the stimulus must resume from the held position. A design that compared stale results or rewound the address would fail here.

A fault held on one bit for longer than 2^16 words checks that the bit counter clamps instead of wrapping. A combinational read port would show the new index one cycle early.

// File: rtl/vecchk_pkg.sv
package vecchk_pkg;

  // 32-bit mixing function used to fill the stimulus table
  function automatic logic [31:0] mix32(input logic [31:0] seed, input logic [31:0] k);
    logic [31:0] x;
    x = seed ^ (k * 32'h9E37_79B9);
    x = x * 32'h7FEB_352D;
    return x ^ (x >> 15);
  endfunction

  // saturating increment helper for counters of any width up to 32
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] vmax);
    return (v == vmax) ? v : v + 32'd1;
  endfunction

endpackage

// File: rtl/vecchk_rom.sv
module vecchk_rom #(
  parameter int          HALF_W = 32,
  parameter int          DEPTH  = 16,
  parameter logic [31:0] SEED   = 32'h1234_5678,
  localparam int         IN_W   = 2 * HALF_W,
  localparam int         OUT_W  = 2 * HALF_W,
  localparam int         ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IN_W-1:0]   stim_o,
  output logic [OUT_W-1:0]  exp_o
);

  logic [IN_W-1:0]  stim_tab [DEPTH];
  logic [OUT_W-1:0] exp_tab  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic [31:0]     hi_raw, lo_raw;
    logic [HALF_W-1:0] hi_h, lo_h;
    assign hi_raw = vecchk_pkg::mix32(SEED, 32'(2 * g));
    assign lo_raw = vecchk_pkg::mix32(SEED, 32'(2 * g + 1));
    assign hi_h   = hi_raw[HALF_W-1:0];
    assign lo_h   = lo_raw[HALF_W-1:0];
    assign stim_tab[g] = {hi_h, lo_h};
    assign exp_tab[g]  = OUT_W'(hi_h) * OUT_W'(lo_h);
  end

  assign stim_o = stim_tab[addr_i];
  assign exp_o  = exp_tab[addr_i];

endmodule

// File: rtl/vecchk_seq.sv
module vecchk_seq #(
  parameter int  IN_W   = 64,
  parameter int  OUT_W  = 64,
  parameter int  DEPTH  = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic [IN_W-1:0]   rom_stim_i,
  input  logic [OUT_W-1:0]  rom_exp_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [IN_W-1:0]   stim_o,
  output logic [OUT_W-1:0]  exp_o,
  output logic              vld_o
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      stim_o <= '0;
      exp_o  <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= run_en;
      if (run_en) begin
        stim_o <= rom_stim_i;
        exp_o  <= rom_exp_i;
        addr_o <= (addr_o == LAST) ? '0 : addr_o + 1'b1;
      end
    end
  end

endmodule

// File: rtl/vecchk_align.sv
module vecchk_align #(
  parameter int W       = 64,
  parameter int LATENCY = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] exp_i,
  input  logic         vld_i,
  output logic [W-1:0] exp_o,
  output logic         vld_o
);

  if (LATENCY == 0) begin : g_pass
    assign exp_o = exp_i;
    assign vld_o = vld_i;
  end else begin : g_pipe
    logic [W-1:0]   exp_q [LATENCY];
    logic [LATENCY-1:0] vld_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= '0;
        for (int s = 0; s < LATENCY; s++) exp_q[s] <= '0;
      end else begin
        exp_q[0] <= exp_i;
        vld_q[0] <= vld_i;
        for (int s = 1; s < LATENCY; s++) begin
          exp_q[s] <= exp_q[s-1];
          vld_q[s] <= vld_q[s-1];
        end
      end
    end

    assign exp_o = exp_q[LATENCY-1];
    assign vld_o = vld_q[LATENCY-1];
  end

endmodule

// File: rtl/vecchk_hist.sv
module vecchk_hist #(
  parameter int  OUT_W  = 64,
  parameter int  HCNT_W = 16,
  localparam int IDX_W  = (OUT_W > 1) ? $clog2(OUT_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_i,
  input  logic [OUT_W-1:0]  diff_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HCNT_W-1:0] rd_cnt_o
);

  localparam logic [HCNT_W-1:0] CMAX = '1;

  logic [HCNT_W-1:0] cnt [OUT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < OUT_W; b++) cnt[b] <= '0;
    end else if (upd_i) begin
      for (int b = 0; b < OUT_W; b++) begin
        if (diff_i[b] && (cnt[b] != CMAX)) cnt[b] <= cnt[b] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt_o <= '0;
    end else if (32'(rd_idx_i) < OUT_W) begin
      rd_cnt_o <= cnt[rd_idx_i];
    end else begin
      rd_cnt_o <= '0;
    end
  end

endmodule

// File: rtl/stored_vector_checker.sv
module stored_vector_checker #(
  parameter int          HALF_W  = 32,
  parameter int          DEPTH   = 16,
  parameter int          LATENCY = 2,
  parameter int          HCNT_W  = 16,
  parameter int          ERR_W   = 32,
  parameter logic [31:0] SEED    = 32'h1234_5678,
  localparam int         IN_W    = 2 * HALF_W,
  localparam int         OUT_W   = 2 * HALF_W,
  localparam int         IDX_W   = $clog2(OUT_W),
  localparam int         ADDR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  output logic [IN_W-1:0]   stim_o,
  output logic              stim_vld_o,
  input  logic [OUT_W-1:0]  res_i,
  output logic              err_flag_o,
  output logic [ERR_W-1:0]  err_cnt_o,
  input  logic [IDX_W-1:0]  hist_idx_i,
  output logic [HCNT_W-1:0] hist_cnt_o
);

  logic [ADDR_W-1:0] addr;
  logic [IN_W-1:0]   rom_stim;
  logic [OUT_W-1:0]  rom_exp;
  logic [OUT_W-1:0]  exp_s;
  logic [OUT_W-1:0]  exp_d;
  logic              vld_d;
  logic [OUT_W-1:0]  diff;
  logic              word_bad;

  vecchk_rom #(.HALF_W(HALF_W), .DEPTH(DEPTH), .SEED(SEED)) u_rom (
    .addr_i (addr),
    .stim_o (rom_stim),
    .exp_o  (rom_exp)
  );

  vecchk_seq #(.IN_W(IN_W), .OUT_W(OUT_W), .DEPTH(DEPTH)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .rom_stim_i (rom_stim),
    .rom_exp_i  (rom_exp),
    .addr_o     (addr),
    .stim_o     (stim_o),
    .exp_o      (exp_s),
    .vld_o      (stim_vld_o)
  );

  vecchk_align #(.W(OUT_W), .LATENCY(LATENCY)) u_align (
    .clk   (clk),
    .rst   (rst),
    .exp_i (exp_s),
    .vld_i (stim_vld_o),
    .exp_o (exp_d),
    .vld_o (vld_d)
  );

  assign diff     = res_i ^ exp_d;
  assign word_bad = vld_d && (|diff);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag_o <= 1'b0;
      err_cnt_o  <= '0;
    end else if (word_bad) begin
      err_flag_o <= 1'b1;
      if (err_cnt_o != '1) err_cnt_o <= err_cnt_o + 1'b1;
    end
  end

  vecchk_hist #(.OUT_W(OUT_W), .HCNT_W(HCNT_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .upd_i    (vld_d),
    .diff_i   (diff),
    .rd_idx_i (hist_idx_i),
    .rd_cnt_o (hist_cnt_o)
  );

endmodule

// File: rtl/stored_vector_checker_sva.sv
module stored_vector_checker_sva #(
  parameter int IN_W  = 64,
  parameter int ERR_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic [IN_W-1:0]  stim_o,
  input logic             stim_vld_o,
  input logic             err_flag_o,
  input logic [ERR_W-1:0] err_cnt_o
);

  assert_pause_vld_R3: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !stim_vld_o);

  assert_pause_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> $stable(stim_o));

  assert_run_vld_R3: assert property (@(posedge clk) disable iff (rst)
    run_en |=> stim_vld_o);

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    err_flag_o |=> err_flag_o);

  assert_cnt_implies_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (err_cnt_o != '0) |-> err_flag_o);

  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
    (err_cnt_o == $past(err_cnt_o)) || (err_cnt_o == $past(err_cnt_o) + ERR_W'(1)));

  assert_flag_rise_counts_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag_o) |-> (err_cnt_o == $past(err_cnt_o) + ERR_W'(1)));

endmodule

bind stored_vector_checker stored_vector_checker_sva #(.IN_W(IN_W), .ERR_W(ERR_W)) i_sva (
  .clk        (clk),
  .rst        (rst),
  .run_en     (run_en),
  .stim_o     (stim_o),
  .stim_vld_o (stim_vld_o),
  .err_flag_o (err_flag_o),
  .err_cnt_o  (err_cnt_o)
);

// File: tb/test_stored_vector_checker.sv
module test_stored_vector_checker;

  localparam int          CLK_PERIOD = 10;
  localparam int          HALF_W     = 32;
  localparam int          IN_W       = 64;
  localparam int          OUT_W      = 64;
  localparam int          DEPTH      = 16;
  localparam int          LAT        = 2;
  localparam int          HCNT_W     = 16;
  localparam int          ERR_W      = 32;
  localparam logic [31:0] SEED       = 32'h1234_5678;

  logic              clk = 1'b0;
  logic              rst;
  logic              run_en;
  logic [IN_W-1:0]   stim;
  logic              stim_vld;
  logic [OUT_W-1:0]  res;
  logic              err_flag;
  logic [ERR_W-1:0]  err_cnt;
  logic [5:0]        hidx;
  logic [HCNT_W-1:0] hcnt;

  logic [OUT_W-1:0]  mask;
  logic [OUT_W-1:0]  p1, p2;
  int                seen;
  int                n_cmp = 0;
  int                n_bad = 0;
  bit                done  = 0;
  logic [ERR_W-1:0]  exp_err = '0;

  stored_vector_checker #(
    .HALF_W(HALF_W), .DEPTH(DEPTH), .LATENCY(LAT),
    .HCNT_W(HCNT_W), .ERR_W(ERR_W), .SEED(SEED)
  ) i_stored_vector_checker (
    .clk(clk), .rst(rst), .run_en(run_en),
    .stim_o(stim), .stim_vld_o(stim_vld), .res_i(res),
    .err_flag_o(err_flag), .err_cnt_o(err_cnt),
    .hist_idx_i(hidx), .hist_cnt_o(hcnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mix(input logic [31:0] k);
    logic [31:0] x;
    x = SEED ^ (k * 32'h9E37_79B9);
    x = x * 32'h7FEB_352D;
    return x ^ (x >> 15);
  endfunction

  function automatic logic [IN_W-1:0] vec(input int i);
    return {mix(32'(2*i)), mix(32'(2*i+1))};
  endfunction

  function automatic logic [OUT_W-1:0] prod(input logic [IN_W-1:0] v);
    return {32'd0, v[63:32]} * {32'd0, v[31:0]};
  endfunction

  // device-under-test model: two-stage multiplier with output fault mask
  always_ff @(posedge clk) begin
    p1 <= prod(stim);
    p2 <= p1;
  end
  assign res = p2 ^ mask;

  // expected table position
  always_ff @(posedge clk) begin
    if (rst) seen <= 0;
    else if (run_en) seen <= seen + 1;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_hist(input int b, output logic [HCNT_W-1:0] v);
    hidx = 6'(b);
    step(1);
    v = hcnt;
  endtask

  task automatic t_reset();
    logic [HCNT_W-1:0] v;
    chk("R9 flag after reset", 64'(err_flag), 64'd0);
    chk("R9 count after reset", 64'(err_cnt), 64'd0);
    chk("R9 valid after reset", 64'(stim_vld), 64'd0);
    rd_hist(0, v);  chk("R9 hist0 after reset", 64'(v), 64'd0);
    rd_hist(63, v); chk("R9 hist63 after reset", 64'(v), 64'd0);
  endtask

  task automatic t_clean();
    run_en = 1'b1;
    for (int c = 0; c < 2*DEPTH + 4; c++) begin
      step(1);
      chk("R3 valid while running", 64'(stim_vld), 64'd1);
      chk("R1 R3 stimulus entry", stim, vec((seen - 1) % DEPTH));
    end
    step(LAT + 1);
    chk("R2 R4 no failures on clean run", 64'(err_cnt), 64'd0);
    chk("R4 flag clear on clean run", 64'(err_flag), 64'd0);
  endtask

  task automatic t_single();
    mask = 64'h1 << 5;
    step(7);
    mask = '0;
    step(LAT + 2);
    exp_err = exp_err + 7;
    chk("R6 single-bit word count", 64'(err_cnt), 64'(exp_err));
    chk("R5 flag set by failure", 64'(err_flag), 64'd1);
  endtask

  task automatic t_multi();
    mask = (64'h1 << 0) | (64'h1 << 31) | (64'h1 << 32) | (64'h1 << 62);
    step(3);
    mask = '0;
    step(LAT + 2);
    exp_err = exp_err + 3;
    chk("R6 multi-bit counts once per word", 64'(err_cnt), 64'(exp_err));
  endtask

  task automatic t_sticky();
    step(20);
    chk("R5 flag stays after clean words", 64'(err_flag), 64'd1);
    chk("R6 count unchanged on clean words", 64'(err_cnt), 64'(exp_err));
  endtask

  task automatic t_read();
    logic [HCNT_W-1:0] v;
    run_en = 1'b0;
    step(LAT + 3);
    rd_hist(5, v);  chk("R7 hist bit5", 64'(v), 64'd7);
    rd_hist(0, v);  chk("R7 hist bit0", 64'(v), 64'd3);
    rd_hist(31, v); chk("R7 hist bit31", 64'(v), 64'd3);
    rd_hist(32, v); chk("R7 hist bit32", 64'(v), 64'd3);
    rd_hist(62, v); chk("R7 hist bit62", 64'(v), 64'd3);
    rd_hist(4, v);  chk("R7 hist bit4 untouched", 64'(v), 64'd0);
    // latency: old value until the next edge
    rd_hist(5, v);
    hidx = 6'd6;
    #1;
    chk("R8 read holds until edge", 64'(hcnt), 64'd7);
    step(1);
    chk("R8 read after one edge", 64'(hcnt), 64'd0);
  endtask

  task automatic t_pause();
    logic [IN_W-1:0]   held;
    logic [HCNT_W-1:0] v;
    logic [ERR_W-1:0]  c0;
    chk("R3 valid low while paused", 64'(stim_vld), 64'd0);
    held = stim;
    c0   = err_cnt;
    mask = '1;
    step(5);
    mask = '0;
    step(2);
    chk("R3 stimulus held while paused", stim, held);
    chk("R4 results ignored while paused", 64'(err_cnt), 64'(c0));
    rd_hist(0, v);
    chk("R4 hist ignored while paused", 64'(v), 64'd3);
    run_en = 1'b1;
    for (int c = 0; c < 3; c++) begin
      step(1);
      chk("R3 resume from held position", stim, vec((seen - 1) % DEPTH));
    end
    step(LAT + 2);
    chk("R4 clean after resume", 64'(err_cnt), 64'(c0));
  endtask

  task automatic t_sat();
    logic [HCNT_W-1:0] v;
    mask = 64'h1 << 63;
    step(65540);
    mask = '0;
    step(LAT + 2);
    exp_err = exp_err + 65540;
    run_en = 1'b0;
    step(LAT + 2);
    rd_hist(63, v); chk("R7 hist saturates", 64'(v), 64'hFFFF);
    rd_hist(62, v); chk("R7 neighbour unchanged", 64'(v), 64'd3);
    chk("R6 long-run word count", 64'(err_cnt), 64'(exp_err));
  endtask

  task automatic t_reset2();
    logic [HCNT_W-1:0] v;
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(1);
    chk("R9 flag cleared", 64'(err_flag), 64'd0);
    chk("R9 count cleared", 64'(err_cnt), 64'd0);
    rd_hist(63, v); chk("R9 hist63 cleared", 64'(v), 64'd0);
    rd_hist(5, v);  chk("R9 hist5 cleared", 64'(v), 64'd0);
    run_en = 1'b1;
    step(1);
    chk("R9 position restarts at entry 0", stim, vec(0));
    run_en = 1'b0;
  endtask

  initial begin
    rst = 1'b1; run_en = 1'b0; mask = '0; hidx = '0;
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_clean();
    t_single();
    t_multi();
    t_sticky();
    t_read();
    t_pause();
    t_sat();
    t_reset2();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule